// File: doc/BRIEF.md
# Issue Buffer Slot Tracker

This block keeps the occupancy state of one issue buffer in front of an execution resource. A single signed size parameter fixes its behaviour at build time. A negative size means the buffer is unlimited. A size of zero makes the resource a dispatch hazard: it is held from dispatch until its execution cycles are over. A size of one gives an in-order buffer, and a larger size gives an out-of-order reservation station with that many slots.

Dispatch logic strobes `take_i` when it claims a slot and `give_i` when an entry leaves. It strobes `hold_set_i` and `hold_clr_i` to hold the resource and to let it go. The block returns a three-way availability code, the number of free slots and the mode flags. It has three small state machines. The slot machine has the states SL_ALL_FREE, SL_PARTIAL and SL_EXHAUSTED. Its transitions are CLAIM_FIRST (SL_ALL_FREE to SL_PARTIAL, or to SL_EXHAUSTED when the size is one), CLAIM_LAST (SL_PARTIAL to SL_EXHAUSTED), RETURN_FIRST (SL_EXHAUSTED to SL_PARTIAL or SL_ALL_FREE) and RETURN_LAST (SL_PARTIAL to SL_ALL_FREE). The hold machine has the states HD_OPEN and HD_HELD, joined by the transitions GRAB (to HD_HELD) and DROP (to HD_OPEN). The third machine is the output process that forms the availability code.

Top module: `slot_tracker`

## Requirements
- R1: `avail_o` encodes 2'b00 = slot available, 2'b01 = no free slot, 2'b10 = held. The held code takes precedence, then the available code, then the no-free-slot code.
- R2: After reset, `free_o` equals the size when the size is positive and 0 otherwise. `held_o` and `ovf_err_o` are low.
- R3: A `take_i` without `give_i` lowers `free_o` by one in the next cycle when it is nonzero. At zero it leaves it at zero, and `avail_o` reads 2'b01 while a positive-size buffer has no free slot.
- R4: A `give_i` without `take_i` raises `free_o` by one when the size is positive and below it. For a size of 0 or less it has no effect on `free_o`.
- R5: A `give_i` without `take_i` while `free_o` already equals a positive size is ignored. `ovf_err_o` is high for exactly the following cycle.
- R6: `take_i` and `give_i` in the same cycle leave `free_o` unchanged and raise no error.
- R7: `buffered_o` is high for size > 0, `in_order_o` for size == 1 and `hazard_o` for size == 0.
- R8: `hold_set_i` sets `held_o` from the next cycle and `hold_clr_i` clears it. When both are asserted, clear wins.
- R9: In hazard mode (size 0), `take_i` also sets `held_o`. While `held_o` is high, `avail_o` is 2'b10, so no further dispatch is allowed.
- R10: For any size other than 0, `held_o` does not change `avail_o`, which depends on free slots only.
- R11: For sizes 0 and -1, `free_o` stays 0 and `avail_o` is 2'b00 unless a hazard-mode hold is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| take_i | input | 1 | Claim one buffer slot |
| give_i | input | 1 | Return one buffer slot |
| hold_set_i | input | 1 | Hold the resource |
| hold_clr_i | input | 1 | Release the hold |
| avail_o | output | 2 | Availability code (R1) |
| free_o | output | CNT_W | Free slot count |
| buffered_o | output | 1 | Size greater than zero |
| in_order_o | output | 1 | Size equals one |
| hazard_o | output | 1 | Size equals zero |
| held_o | output | 1 | Hold state |
| ovf_err_o | output | 1 | Overflowing return was dropped |

## Verification
The bench builds four instances side by side with sizes 3, 0, -1 and 1, and drives the same strobes into all of them. This covers every mode. The size-3 instance visits all three slot states, including the partial one. The size-1 instance jumps straight between full and empty. Sizes 0 and -1 show that returns have no effect on an unbuffered resource and that a hold blocks dispatch only in hazard mode. Overflowing returns, claims at zero and simultaneous claim and return occur in directed steps and again at random.

// File: rtl/slot_trk_pkg.sv
package slot_trk_pkg;

    typedef enum logic [1:0] {
        AVL_OPEN = 2'b00,
        AVL_FULL = 2'b01,
        AVL_HELD = 2'b10
    } avail_t;

    typedef enum logic [1:0] {
        SL_ALL_FREE  = 2'b00,
        SL_PARTIAL   = 2'b01,
        SL_EXHAUSTED = 2'b10
    } slot_st_t;

    typedef enum logic {
        HD_OPEN = 1'b0,
        HD_HELD = 1'b1
    } hold_st_t;

    function automatic int cap_of(input int size);
        return (size > 0) ? size : 1;
    endfunction

endpackage

// File: rtl/slot_mode_dec.sv
module slot_mode_dec #(
    parameter int BUF_SIZE = 4
) (
    output logic buffered_o,
    output logic in_order_o,
    output logic hazard_o
);
    generate
        if (BUF_SIZE > 1) begin : g_ooo
            assign buffered_o = 1'b1;
            assign in_order_o = 1'b0;
            assign hazard_o   = 1'b0;
        end else if (BUF_SIZE == 1) begin : g_inord
            assign buffered_o = 1'b1;
            assign in_order_o = 1'b1;
            assign hazard_o   = 1'b0;
        end else if (BUF_SIZE == 0) begin : g_hazard
            assign buffered_o = 1'b0;
            assign in_order_o = 1'b0;
            assign hazard_o   = 1'b1;
        end else begin : g_unlim
            assign buffered_o = 1'b0;
            assign in_order_o = 1'b0;
            assign hazard_o   = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/slot_counter.sv
module slot_counter
    import slot_trk_pkg::*;
#(
    parameter int BUF_SIZE = 4,
    localparam int CAP   = cap_of(BUF_SIZE),
    localparam int CNT_W = $clog2(CAP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  logic             give_i,
    output logic [CNT_W-1:0] free_o,
    output logic             exhausted_o,
    output logic             ovf_err_o
);
    generate
        if (BUF_SIZE > 0) begin : g_slots
            localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAP);
            localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

            slot_st_t         st_q, st_d;
            logic [CNT_W-1:0] cnt_q, cnt_d;
            logic             err_q;
            logic             inc, dec, ovf;

            always_comb begin
                inc = give_i && !take_i && (cnt_q != CAP_V);
                dec = take_i && !give_i && (cnt_q != '0);
                ovf = give_i && !take_i && (cnt_q == CAP_V);
                cnt_d = cnt_q;
                if (inc) cnt_d = cnt_q + ONE_V;
                else if (dec) cnt_d = cnt_q - ONE_V;
            end

            always_comb begin
                st_d = st_q;
                unique case (st_q)
                    SL_ALL_FREE: begin
                        if (dec) st_d = (CAP == 1) ? SL_EXHAUSTED : SL_PARTIAL;
                    end
                    SL_PARTIAL: begin
                        if (inc && (cnt_q == CAP_V - ONE_V)) st_d = SL_ALL_FREE;
                        else if (dec && (cnt_q == ONE_V))   st_d = SL_EXHAUSTED;
                    end
                    SL_EXHAUSTED: begin
                        if (inc) st_d = (CAP == 1) ? SL_ALL_FREE : SL_PARTIAL;
                    end
                    default: st_d = SL_ALL_FREE;
                endcase
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q  <= SL_ALL_FREE;
                    cnt_q <= CAP_V;
                    err_q <= 1'b0;
                end else begin
                    st_q  <= st_d;
                    cnt_q <= cnt_d;
                    err_q <= ovf;
                end
            end

            assign free_o      = cnt_q;
            assign exhausted_o = (st_q == SL_EXHAUSTED);
            assign ovf_err_o   = err_q;
        end else begin : g_none
            logic unused_in;
            assign unused_in   = clk ^ rst_n ^ take_i ^ give_i;
            assign free_o      = '0;
            assign exhausted_o = 1'b0;
            assign ovf_err_o   = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
    import slot_trk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic grab_i,
    input  logic drop_i,
    output logic held_o
);
    hold_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            HD_OPEN: if (grab_i && !drop_i) st_d = HD_HELD;
            HD_HELD: if (drop_i)            st_d = HD_OPEN;
            default: st_d = HD_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= HD_OPEN;
        else        st_q <= st_d;
    end

    assign held_o = (st_q == HD_HELD);
endmodule

// File: rtl/slot_tracker.sv
module slot_tracker
    import slot_trk_pkg::*;
#(
    parameter int BUF_SIZE = 4,
    localparam int CAP   = cap_of(BUF_SIZE),
    localparam int CNT_W = $clog2(CAP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  logic             give_i,
    input  logic             hold_set_i,
    input  logic             hold_clr_i,
    output logic [1:0]       avail_o,
    output logic [CNT_W-1:0] free_o,
    output logic             buffered_o,
    output logic             in_order_o,
    output logic             hazard_o,
    output logic             held_o,
    output logic             ovf_err_o
);
    logic exhausted;
    logic grab;
    avail_t avail;

    slot_mode_dec #(.BUF_SIZE(BUF_SIZE)) u_mode (
        .buffered_o (buffered_o),
        .in_order_o (in_order_o),
        .hazard_o   (hazard_o)
    );

    slot_counter #(.BUF_SIZE(BUF_SIZE)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_i      (take_i),
        .give_i      (give_i),
        .free_o      (free_o),
        .exhausted_o (exhausted),
        .ovf_err_o   (ovf_err_o)
    );

    // a dispatch-hazard resource is grabbed by the dispatch itself
    assign grab = hold_set_i || (hazard_o && take_i);

    hold_fsm u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .grab_i (grab),
        .drop_i (hold_clr_i),
        .held_o (held_o)
    );

    always_comb begin
        unique case ({hazard_o && held_o, exhausted})
            2'b00:   avail = AVL_OPEN;
            2'b01:   avail = AVL_FULL;
            default: avail = AVL_HELD;
        endcase
    end

    assign avail_o = avail;
endmodule

// File: rtl/slot_tracker_chk.sv
module slot_tracker_chk #(
    parameter int BUF_SIZE = 4,
    parameter int CNT_W = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             take_i,
    input logic             give_i,
    input logic             hold_set_i,
    input logic             hold_clr_i,
    input logic [1:0]       avail_o,
    input logic [CNT_W-1:0] free_o,
    input logic             buffered_o,
    input logic             hazard_o,
    input logic             held_o,
    input logic             ovf_err_o
);
    localparam int SZ = (BUF_SIZE > 0) ? BUF_SIZE : 0;

    AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(free_o) <= SZ); // R4

    AST_TAKE_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !give_i && free_o != '0) |=> (int'(free_o) == int'($past(free_o)) - 1)); // R3

    AST_BOTH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && give_i) |=> ($stable(free_o) && !ovf_err_o)); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (buffered_o && give_i && !take_i && int'(free_o) == SZ) |=> (ovf_err_o && $stable(free_o))); // R5

    AST_HAZ_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (hazard_o && held_o) |-> (avail_o == 2'b10)); // R9

    AST_UNBUF_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!buffered_o && !(hazard_o && held_o)) |-> (avail_o == 2'b00)); // R11

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hold_clr_i |=> !held_o); // R8
endmodule

bind slot_tracker slot_tracker_chk #(.BUF_SIZE(BUF_SIZE), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_i     (take_i),
    .give_i     (give_i),
    .hold_set_i (hold_set_i),
    .hold_clr_i (hold_clr_i),
    .avail_o    (avail_o),
    .free_o     (free_o),
    .buffered_o (buffered_o),
    .hazard_o   (hazard_o),
    .held_o     (held_o),
    .ovf_err_o  (ovf_err_o)
);

// File: tb/slot_tracker_tb.sv
`timescale 1ns/1ps
module slot_tracker_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic take = 1'b0, give = 1'b0, hset = 1'b0, hclr = 1'b0;
    always #2 clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam int NI = 4;
    int sizes [NI] = '{3, 0, -1, 1};
    int m_cnt [NI];
    bit m_held[NI];
    bit m_err [NI];

    logic [1:0] av  [NI];
    int         fr  [NI];
    logic       bf  [NI], io [NI], hz [NI], hd [NI], er [NI];

    logic [1:0] fr0;
    logic       fr1, fr2, fr3;

    slot_tracker #(.BUF_SIZE(3)) u_dut (.clk(clk), .rst_n(rst_n), .take_i(take), .give_i(give),
        .hold_set_i(hset), .hold_clr_i(hclr), .avail_o(av[0]), .free_o(fr0), .buffered_o(bf[0]),
        .in_order_o(io[0]), .hazard_o(hz[0]), .held_o(hd[0]), .ovf_err_o(er[0]));
    slot_tracker #(.BUF_SIZE(0)) u_dut_haz (.clk(clk), .rst_n(rst_n), .take_i(take), .give_i(give),
        .hold_set_i(hset), .hold_clr_i(hclr), .avail_o(av[1]), .free_o(fr1), .buffered_o(bf[1]),
        .in_order_o(io[1]), .hazard_o(hz[1]), .held_o(hd[1]), .ovf_err_o(er[1]));
    slot_tracker #(.BUF_SIZE(-1)) u_dut_unl (.clk(clk), .rst_n(rst_n), .take_i(take), .give_i(give),
        .hold_set_i(hset), .hold_clr_i(hclr), .avail_o(av[2]), .free_o(fr2), .buffered_o(bf[2]),
        .in_order_o(io[2]), .hazard_o(hz[2]), .held_o(hd[2]), .ovf_err_o(er[2]));
    slot_tracker #(.BUF_SIZE(1)) u_dut_ino (.clk(clk), .rst_n(rst_n), .take_i(take), .give_i(give),
        .hold_set_i(hset), .hold_clr_i(hclr), .avail_o(av[3]), .free_o(fr3), .buffered_o(bf[3]),
        .in_order_o(io[3]), .hazard_o(hz[3]), .held_o(hd[3]), .ovf_err_o(er[3]));

    always_comb begin
        fr[0] = int'(fr0); fr[1] = int'(fr1); fr[2] = int'(fr2); fr[3] = int'(fr3);
    end

    // R1: 00 available, 01 no free slot, 10 held (hazard only, R9/R10)
    function automatic logic [1:0] exp_avail(input int sz, input int cnt, input bit held);
        if (sz == 0 && held) return 2'b10;
        if (sz <= 0 || cnt != 0) return 2'b00;
        return 2'b01;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NI; i++) begin
            m_cnt[i]  = (sizes[i] > 0) ? sizes[i] : 0;
            m_held[i] = 1'b0;
            m_err[i]  = 1'b0;
        end
    endtask

    task automatic model_step(input bit t, input bit g, input bit s, input bit c);
        for (int i = 0; i < NI; i++) begin
            m_err[i] = 1'b0;
            if (sizes[i] > 0 && !(t && g)) begin
                if (g) begin
                    if (m_cnt[i] == sizes[i]) m_err[i] = 1'b1;
                    else m_cnt[i]++;
                end else if (t && m_cnt[i] > 0) m_cnt[i]--;
            end
            if (c) m_held[i] = 1'b0;
            else if (s || (sizes[i] == 0 && t)) m_held[i] = 1'b1;
        end
    endtask

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        for (int i = 0; i < NI; i++) begin
            chk(tag, $sformatf("avail[size %0d]", sizes[i]), int'(av[i]),
                int'(exp_avail(sizes[i], m_cnt[i], m_held[i])));
            chk(tag, $sformatf("free[size %0d]", sizes[i]), fr[i], m_cnt[i]);
            chk(tag, $sformatf("held[size %0d]", sizes[i]), int'(hd[i]), int'(m_held[i]));
            chk(tag, $sformatf("ovf[size %0d]", sizes[i]), int'(er[i]), int'(m_err[i]));
            chk("R7", $sformatf("flags[size %0d]", sizes[i]), int'({bf[i], io[i], hz[i]}),
                int'({sizes[i] > 0, sizes[i] == 1, sizes[i] == 0}));
        end
    endtask

    task automatic step(input string tag, input bit t, input bit g, input bit s, input bit c);
        @(negedge clk);
        take = t; give = g; hset = s; hclr = c;
        @(posedge clk);
        model_step(t, g, s, c);
        #1;
        compare(tag);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd2718);
        model_reset();
        #9;
        compare("R2");
        rst_n = 1'b1;
        // R3: drain size-3 buffer, then claim at zero
        step("R3", 1, 0, 0, 0);
        step("R3", 1, 0, 0, 0);
        step("R3", 1, 0, 0, 0);
        step("R3", 1, 0, 0, 0);
        // R6: simultaneous claim and return
        step("R6", 1, 1, 0, 0);
        // R4: return slots, hazard/unlimited unaffected (R11)
        step("R4", 0, 1, 0, 0);
        step("R11", 0, 1, 0, 0);
        step("R4", 0, 1, 0, 0);
        // R5: return while full
        step("R5", 0, 1, 0, 0);
        step("R5", 0, 0, 0, 0);
        // R8: hold set, then set with clear
        step("R8", 0, 0, 1, 0);
        step("R10", 0, 0, 0, 0);
        step("R8", 0, 0, 1, 1);
        // R9: hazard claim grabs the resource
        step("R9", 1, 0, 0, 0);
        step("R9", 0, 0, 0, 0);
        step("R8", 0, 0, 0, 1);
        // R1: random mix
        for (int k = 0; k < 3000; k++) begin
            logic [7:0] r;
            r = 8'($urandom);
            step("R1", r[0], r[1], r[2] & r[3] & r[4], r[5] & r[6]);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule